// File: doc/BRIEF.md
# Directory home node controller

This block is the home node for a small group of cache lines in a multiprocessor whose cores talk over point-to-point links. For every line it keeps a stable coherence state (uncached, shared or modified), the identifier of the core that holds a dirty copy, and a bit-vector of cores holding clean copies. A small backing memory holds the home copy of each line's data.

Cores send read, read-exclusive and writeback requests on a request channel. Recall data, forwarded-read completions and invalidate acknowledgements come back on a response channel. The home sends fills, recalls, forwarded reads, invalidates and writeback acknowledgements on one message channel. Every message is addressed to a single core that the directory has on record. A static mode input selects how a read to a modified line is resolved. In one mode the home recalls the line and then replies itself (four hops). In the other mode it forwards the read to the owner, and the owner answers the requester directly (three hops). The controller runs one transaction at a time. New requests wait until that transaction is finished. The one exception is a writeback from the owner that crosses an outstanding forwarded read: it is accepted and resolved as a race.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is uncached, no message is valid, the request channel is ready, and the home copy of line i holds (i*29+5) mod 2^DATA_W.
- R2: A read (req_kind 0) to a line that is not modified produces a shared fill (msg_kind 0) to the requester with the home data and the request's line. The requester becomes a sharer and the line becomes shared.
- R3: With three_hop low, a read to a modified line sends a recall (msg_kind 2) to the owner. When the owner's recall data arrives (rsp_kind 1), the home copy is updated and a shared fill carrying that data goes to the requester. The old owner stays on record as a sharer.
- R4: With three_hop high, a read to a modified line sends a forwarded read (msg_kind 3) to the owner, with msg_req naming the requester, and the home sends no fill itself. When the owner's completion arrives (rsp_kind 2), the home copy is updated from it and both cores become sharers.
- R5: A read-exclusive (req_kind 1) sends one invalidate (msg_kind 4) to each other holder, one per handshake, in ascending core order. It then sends an exclusive fill (msg_kind 1) only after the same number of invalidate acknowledgements (rsp_kind 0) have arrived. An acknowledgement with rsp_dirty set writes its data to the home copy.
- R6: A read-exclusive to a line with no holder other than the requester sends the exclusive fill at once, with no invalidate.
- R7: Invalidates, recalls and forwarded reads go only to cores the directory records as sharer or owner of that line.
- R8: A writeback (req_kind 2) from the recorded owner with no race pending writes the home copy, sends a writeback acknowledgement (msg_kind 5) to the writer, and leaves the line uncached.
- R9: A writeback from the owner that arrives while a forwarded read to that line is outstanding is accepted and updates the home copy but is never acknowledged. After the completion arrives, the requester is the line's only sharer.
- R10: While a transaction is in progress, req_ready stays low for every request except the racing writeback of R9.
- R11: A writeback from a core that is not the recorded owner sends no message and changes neither the home copy nor the directory entry.
- R12: While msg_valid is high and msg_ready is low, msg_valid, msg_kind, msg_dst and msg_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| three_hop | input | 1 | 1: forward reads of modified lines to the owner; 0: recall the line first |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 read, 1 read-exclusive, 2 writeback |
| req_src | input | clog2(N_CORES) | Requesting core |
| req_line | input | clog2(N_LINES) | Line index |
| req_data | input | DATA_W | Writeback data |
| rsp_valid | input | 1 | Core response present |
| rsp_ready | output | 1 | Response accepted (always high) |
| rsp_kind | input | 2 | 0 invalidate ack, 1 recall data, 2 forwarded-read done |
| rsp_src | input | clog2(N_CORES) | Responding core |
| rsp_line | input | clog2(N_LINES) | Line index |
| rsp_dirty | input | 1 | Response carries dirty data |
| rsp_data | input | DATA_W | Response data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Outgoing message taken |
| msg_kind | output | 3 | 0 shared fill, 1 exclusive fill, 2 recall, 3 forwarded read, 4 invalidate, 5 writeback ack |
| msg_dst | output | clog2(N_CORES) | Destination core |
| msg_line | output | clog2(N_LINES) | Line index |
| msg_req | output | clog2(N_CORES) | Original requester (used by forwarded reads) |
| msg_data | output | DATA_W | Fill data |

## Verification
Several properties are checked on every cycle by assertions. Every invalidate, recall or forward targets a recorded holder. No exclusive fill leaves while acknowledgements are pending. The acknowledgement counter never underflows. A modified entry is never written with sharers. A writeback acknowledgement only follows an uncached entry. Only the racing writeback gets past a busy controller. Outgoing messages hold steady under backpressure. Other behaviour can only be shown by the bench's scenarios: the data that actually lands in the home copy, the difference between the four-hop and three-hop paths, the final sharer sets after a recall or a race (seen through the invalidates a later read-exclusive sends), and the fact that a writeback from a non-owner is silently dropped.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    L_UNC = 2'd0,
    L_SHD = 2'd1,
    L_MOD = 2'd2
  } line_st_e;

  localparam logic [1:0] RQ_RD  = 2'd0;
  localparam logic [1:0] RQ_RDX = 2'd1;
  localparam logic [1:0] RQ_WB  = 2'd2;

  localparam logic [1:0] RS_INV_ACK = 2'd0;
  localparam logic [1:0] RS_RCL_DAT = 2'd1;
  localparam logic [1:0] RS_FWD_DON = 2'd2;

  localparam logic [2:0] MK_FILL_S = 3'd0;
  localparam logic [2:0] MK_FILL_M = 3'd1;
  localparam logic [2:0] MK_RECALL = 3'd2;
  localparam logic [2:0] MK_FWD_RD = 3'd3;
  localparam logic [2:0] MK_INV    = 3'd4;
  localparam logic [2:0] MK_WB_ACK = 3'd5;

  // number of set bits in a holder vector
  function automatic int count_ones(logic [31:0] v);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  // index of the lowest set bit (0 when none)
  function automatic int lowest_set(logic [31:0] v);
    int p;
    p = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) p = i;
    return p;
  endfunction

  // home copy contents after reset
  function automatic logic [31:0] boot_word(int idx);
    return 32'(idx * 29 + 5);
  endfunction

endpackage

// File: rtl/dir_line_table.sv
module dir_line_table
  import dir_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int N_CORES = 4,
  localparam int LW = $clog2(N_LINES),
  localparam int CW = $clog2(N_CORES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LW-1:0]      rd_idx,
  output line_st_e           rd_st,
  output logic [CW-1:0]      rd_owner,
  output logic [N_CORES-1:0] rd_sharers,
  input  logic               we,
  input  logic [LW-1:0]      wr_idx,
  input  line_st_e           wr_st,
  input  logic [CW-1:0]      wr_owner,
  input  logic [N_CORES-1:0] wr_sharers
);

  line_st_e           st_q  [N_LINES];
  logic [CW-1:0]      own_q [N_LINES];
  logic [N_CORES-1:0] sh_q  [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= L_UNC;
        own_q[g] <= '0;
        sh_q[g]  <= '0;
      end else if (we && wr_idx == LW'(g)) begin
        st_q[g]  <= wr_st;
        own_q[g] <= wr_owner;
        sh_q[g]  <= wr_sharers;
      end
    end
  end

  assign rd_st      = st_q[rd_idx];
  assign rd_owner   = own_q[rd_idx];
  assign rd_sharers = sh_q[rd_idx];

  AST_MOD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    we && wr_st == L_MOD |-> wr_sharers == '0); // R5

endmodule

// File: rtl/dir_backing_mem.sv
module dir_backing_mem
  import dir_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int DATA_W  = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [LW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] word_q [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                        word_q[g] <= DATA_W'(boot_word(g));
      else if (we && wr_idx == LW'(g))   word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/dir_ack_counter.sv
module dir_ack_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !load |-> !zero); // R5

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_LINES = 4,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       three_hop,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_kind,
  input  logic [$clog2(N_CORES)-1:0] req_src,
  input  logic [$clog2(N_LINES)-1:0] req_line,
  input  logic [DATA_W-1:0]          req_data,
  input  logic                       rsp_valid,
  output logic                       rsp_ready,
  input  logic [1:0]                 rsp_kind,
  input  logic [$clog2(N_CORES)-1:0] rsp_src,
  input  logic [$clog2(N_LINES)-1:0] rsp_line,
  input  logic                       rsp_dirty,
  input  logic [DATA_W-1:0]          rsp_data,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [2:0]                 msg_kind,
  output logic [$clog2(N_CORES)-1:0] msg_dst,
  output logic [$clog2(N_LINES)-1:0] msg_line,
  output logic [$clog2(N_CORES)-1:0] msg_req,
  output logic [DATA_W-1:0]          msg_data
);

  localparam int CW = $clog2(N_CORES);
  localparam int LW = $clog2(N_LINES);
  localparam int AW = $clog2(N_CORES + 1);
  localparam logic [N_CORES-1:0] BIT0 = N_CORES'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_INV, S_WAIT_ACK, S_FILL, S_RECALL,
    S_WAIT_RCL, S_FWD, S_WAIT_FWD, S_WBACK
  } fsm_e;

  fsm_e               st, nx;
  logic [LW-1:0]      cur_line;
  logic [CW-1:0]      cur_src;
  logic               cur_excl;
  logic [N_CORES-1:0] tgt, nx_tgt;
  logic               race, nx_race;

  // directory entry of the selected line
  logic [LW-1:0]      line_sel;
  line_st_e           t_st;
  logic [CW-1:0]      t_owner;
  logic [N_CORES-1:0] t_sh;
  logic               tbl_we;
  line_st_e           tbl_wst;
  logic [CW-1:0]      tbl_wown;
  logic [N_CORES-1:0] tbl_wsh;

  logic [DATA_W-1:0]  mem_rd;
  logic               mem_we;
  logic [DATA_W-1:0]  mem_wd;

  logic               cnt_load;
  logic [AW-1:0]      cnt_val;
  logic               ack_zero;

  // named internal events
  logic               req_fire, msg_fire;
  logic               ack_hit, rcl_hit, fwd_hit, race_wb, race_now;
  logic [N_CORES-1:0] owner_bit, src_bit, rdx_tgt;
  logic [CW-1:0]      inv_dst;

  assign line_sel  = (st == S_IDLE) ? req_line : cur_line;
  assign owner_bit = BIT0 << t_owner;
  assign src_bit   = BIT0 << cur_src;
  assign rdx_tgt   = ((t_st == L_MOD) ? owner_bit : t_sh) & ~(BIT0 << req_src);
  assign inv_dst   = CW'(lowest_set(32'(tgt)));

  assign race_wb  = (st == S_WAIT_FWD) && req_valid && req_kind == RQ_WB &&
                    req_src == t_owner && req_line == cur_line;
  assign race_now = race || race_wb;
  assign ack_hit  = (st == S_INV || st == S_WAIT_ACK) && rsp_valid &&
                    rsp_kind == RS_INV_ACK && rsp_line == cur_line;
  assign rcl_hit  = (st == S_WAIT_RCL) && rsp_valid && rsp_kind == RS_RCL_DAT &&
                    rsp_src == t_owner && rsp_line == cur_line;
  assign fwd_hit  = (st == S_WAIT_FWD) && rsp_valid && rsp_kind == RS_FWD_DON &&
                    rsp_src == t_owner && rsp_line == cur_line;

  assign req_ready = (st == S_IDLE) || race_wb;
  assign rsp_ready = 1'b1;
  assign req_fire  = req_valid && req_ready;
  assign msg_fire  = msg_valid && msg_ready;

  dir_line_table #(.N_LINES(N_LINES), .N_CORES(N_CORES)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_idx(line_sel),
    .rd_st(t_st), .rd_owner(t_owner), .rd_sharers(t_sh),
    .we(tbl_we), .wr_idx(line_sel), .wr_st(tbl_wst),
    .wr_owner(tbl_wown), .wr_sharers(tbl_wsh)
  );

  dir_backing_mem #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_idx(cur_line), .rd_data(mem_rd),
    .we(mem_we), .wr_idx(line_sel), .wr_data(mem_wd)
  );

  dir_ack_counter #(.CNT_W(AW)) u_acks (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(ack_hit), .zero(ack_zero)
  );

  always_comb begin
    nx       = st;
    nx_tgt   = tgt;
    nx_race  = race;
    tbl_we   = 1'b0;
    tbl_wst  = t_st;
    tbl_wown = t_owner;
    tbl_wsh  = t_sh;
    mem_we   = 1'b0;
    mem_wd   = req_data;
    cnt_load = 1'b0;
    cnt_val  = '0;

    if (ack_hit && rsp_dirty) begin
      mem_we = 1'b1;
      mem_wd = rsp_data;
    end

    unique case (st)
      S_IDLE: if (req_valid) begin
        unique case (req_kind)
          RQ_RD:  nx = (t_st != L_MOD) ? S_FILL : (three_hop ? S_FWD : S_RECALL);
          RQ_RDX: begin
            cnt_load = 1'b1;
            cnt_val  = AW'(count_ones(32'(rdx_tgt)));
            nx_tgt   = rdx_tgt;
            nx       = (rdx_tgt == '0) ? S_FILL : S_INV;
          end
          RQ_WB: if (t_st == L_MOD && t_owner == req_src) begin
            mem_we   = 1'b1;
            mem_wd   = req_data;
            tbl_we   = 1'b1;
            tbl_wst  = L_UNC;
            tbl_wown = '0;
            tbl_wsh  = '0;
            nx       = S_WBACK;
          end
          default: ;
        endcase
      end
      S_INV: if (msg_fire) begin
        nx_tgt = tgt & ~(BIT0 << inv_dst);
        if (nx_tgt == '0) nx = S_WAIT_ACK;
      end
      S_WAIT_ACK: if (ack_zero) nx = S_FILL;
      S_FILL: if (msg_fire) begin
        tbl_we = 1'b1;
        if (cur_excl) begin
          tbl_wst  = L_MOD;
          tbl_wown = cur_src;
          tbl_wsh  = '0;
        end else begin
          tbl_wst  = L_SHD;
          tbl_wsh  = t_sh | src_bit;
        end
        nx = S_IDLE;
      end
      S_RECALL: if (msg_fire) nx = S_WAIT_RCL;
      S_WAIT_RCL: if (rcl_hit) begin
        mem_we  = 1'b1;
        mem_wd  = rsp_data;
        tbl_we  = 1'b1;
        tbl_wst = L_SHD;
        tbl_wsh = owner_bit;
        nx      = S_FILL;
      end
      S_FWD: if (msg_fire) begin
        nx_race = 1'b0;
        nx      = S_WAIT_FWD;
      end
      S_WAIT_FWD: begin
        if (race_wb) begin
          mem_we  = 1'b1;
          mem_wd  = req_data;
          nx_race = 1'b1;
        end
        if (fwd_hit) begin
          if (!race_now) begin
            mem_we = 1'b1;
            mem_wd = rsp_data;
          end
          tbl_we  = 1'b1;
          tbl_wst = L_SHD;
          tbl_wsh = src_bit | (race_now ? '0 : owner_bit);
          nx_race = 1'b0;
          nx      = S_IDLE;
        end
      end
      S_WBACK: if (msg_fire) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_line <= '0;
      cur_src  <= '0;
      cur_excl <= 1'b0;
      tgt      <= '0;
      race     <= 1'b0;
    end else begin
      st   <= nx;
      tgt  <= nx_tgt;
      race <= nx_race;
      if (st == S_IDLE && req_fire) begin
        cur_line <= req_line;
        cur_src  <= req_src;
        cur_excl <= (req_kind == RQ_RDX);
      end
    end
  end

  always_comb begin
    msg_valid = 1'b0;
    msg_kind  = MK_FILL_S;
    msg_dst   = cur_src;
    msg_data  = '0;
    unique case (st)
      S_INV:    begin msg_valid = 1'b1; msg_kind = MK_INV;    msg_dst = inv_dst; end
      S_FILL:   begin msg_valid = 1'b1; msg_kind = cur_excl ? MK_FILL_M : MK_FILL_S;
                      msg_data = mem_rd; end
      S_RECALL: begin msg_valid = 1'b1; msg_kind = MK_RECALL; msg_dst = t_owner; end
      S_FWD:    begin msg_valid = 1'b1; msg_kind = MK_FWD_RD; msg_dst = t_owner; end
      S_WBACK:  begin msg_valid = 1'b1; msg_kind = MK_WB_ACK; end
      default: ;
    endcase
  end

  assign msg_line = cur_line;
  assign msg_req  = cur_src;

  AST_INV_TO_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_INV |->
      t_sh[msg_dst] || (t_st == L_MOD && t_owner == msg_dst)); // R7
  AST_OWNER_TARGETED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_kind == MK_RECALL || msg_kind == MK_FWD_RD) |->
      t_st == L_MOD && t_owner == msg_dst); // R7
  AST_FILLM_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_FILL_M |-> ack_zero); // R5
  AST_WBACK_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_WB_ACK |-> t_st == L_UNC); // R8
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && st != S_IDLE |-> st == S_WAIT_FWD && req_kind == RQ_WB); // R10
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) &&
      $stable(msg_dst) && $stable(msg_data)); // R12

endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;

  localparam int NC = 4;
  localparam int NL = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic three_hop = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [1:0] req_src = '0, req_line = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [1:0] rsp_kind = '0, rsp_src = '0, rsp_line = '0;
  logic rsp_dirty = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic msg_valid, msg_ready = 1'b0;
  logic [2:0] msg_kind;
  logic [1:0] msg_dst, msg_line, msg_req;
  logic [DW-1:0] msg_data;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dir_home_ctrl #(.N_CORES(NC), .N_LINES(NL), .DATA_W(DW)) i_dir_home_ctrl (
    .clk, .rst_n, .three_hop, .req_valid, .req_ready, .req_kind, .req_src,
    .req_line, .req_data, .rsp_valid, .rsp_ready, .rsp_kind, .rsp_src,
    .rsp_line, .rsp_dirty, .rsp_data, .msg_valid, .msg_ready, .msg_kind,
    .msg_dst, .msg_line, .msg_req, .msg_data
  );

  function automatic int boot_val(int i);
    return (i * 29 + 5) % 256;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send_req(int kind, int src, int line, int data, string tag);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_src = 2'(src);
    req_line = 2'(line); req_data = DW'(data);
    #1;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    chk(n < 50, tag, "request accepted", n, 0);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic send_rsp(int kind, int src, int line, bit dirty, int data);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = 2'(kind); rsp_src = 2'(src);
    rsp_line = 2'(line); rsp_dirty = dirty; rsp_data = DW'(data);
    @(posedge clk); #1 rsp_valid = 1'b0;
  endtask

  task automatic expect_msg(int kind, int dst, int line, int data, string tag);
    int n = 0;
    @(negedge clk);
    while (!msg_valid && n < 50) begin @(negedge clk); n++; end
    chk(msg_valid, tag, "message valid", int'(msg_valid), 1);
    chk(msg_kind == 3'(kind), tag, "message kind", int'(msg_kind), kind);
    chk(msg_dst == 2'(dst), tag, "message destination", int'(msg_dst), dst);
    chk(msg_line == 2'(line), tag, "message line", int'(msg_line), line);
    if (data >= 0) chk(msg_data == DW'(data), tag, "message data", int'(msg_data), data);
    msg_ready = 1'b1;
    @(posedge clk); #1 msg_ready = 1'b0;
  endtask

  task automatic expect_quiet(int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!msg_valid, tag, "no message", int'(msg_valid), 0);
    end
  endtask

  // reset state and a first read with backpressure
  task automatic t_reset_and_read();
    logic [2:0] k0; logic [1:0] d0; logic [DW-1:0] v0;
    @(negedge clk);
    chk(!msg_valid, "R1", "msg_valid after reset", int'(msg_valid), 0);
    chk(req_ready, "R1", "req_ready after reset", int'(req_ready), 1);
    send_req(0, 1, 0, 0, "R2");
    @(negedge clk);
    k0 = msg_kind; d0 = msg_dst; v0 = msg_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(msg_valid && msg_kind == k0 && msg_dst == d0 && msg_data == v0,
          "R12", "message held under backpressure", int'(msg_data), int'(v0));
    end
    expect_msg(0, 1, 0, boot_val(0), "R1");
  endtask

  // second sharer, then read-exclusive with two invalidates and a held request
  task automatic t_exclusive_with_acks();
    send_req(0, 2, 0, 0, "R2");
    expect_msg(0, 2, 0, boot_val(0), "R2");
    send_req(1, 3, 0, 0, "R5");
    expect_msg(4, 1, 0, -1, "R5 R7");
    expect_msg(4, 2, 0, -1, "R5 R7");
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_src = 2'd0; req_line = 2'd3;
    #1 chk(!req_ready, "R10", "held while busy", int'(req_ready), 0);
    expect_quiet(2, "R5");
    send_rsp(0, 1, 0, 1'b0, 0);
    chk(!req_ready, "R10", "held while busy", int'(req_ready), 0);
    expect_quiet(2, "R5");
    send_rsp(0, 2, 0, 1'b0, 0);
    expect_msg(1, 3, 0, boot_val(0), "R5");
    @(posedge clk); #1 req_valid = 1'b0;
    expect_msg(0, 0, 3, boot_val(3), "R10");
  endtask

  // four-hop read of a modified line
  task automatic t_recall_path();
    three_hop = 1'b0;
    send_req(0, 0, 0, 0, "R3");
    expect_msg(2, 3, 0, -1, "R3");
    expect_quiet(2, "R3");
    send_rsp(1, 3, 0, 1'b1, 165);
    expect_msg(0, 0, 0, 165, "R3");
    send_req(1, 0, 0, 0, "R3");
    expect_msg(4, 3, 0, -1, "R3");
    send_rsp(0, 3, 0, 1'b0, 0);
    expect_msg(1, 0, 0, 165, "R3");
  endtask

  // no-holder exclusive, then three-hop forward
  task automatic t_forward_path();
    send_req(1, 2, 1, 0, "R6");
    expect_msg(1, 2, 1, boot_val(1), "R6");
    three_hop = 1'b1;
    send_req(0, 1, 1, 0, "R4");
    @(negedge clk);
    chk(msg_req == 2'd1, "R4", "forward names requester", int'(msg_req), 1);
    expect_msg(3, 2, 1, -1, "R4");
    expect_quiet(3, "R4");
    send_rsp(2, 2, 1, 1'b1, 60);
    send_req(1, 3, 1, 0, "R4");
    expect_msg(4, 1, 1, -1, "R4");
    expect_msg(4, 2, 1, -1, "R4");
    send_rsp(0, 1, 1, 1'b0, 0);
    send_rsp(0, 2, 1, 1'b0, 0);
    expect_msg(1, 3, 1, 60, "R4");
  endtask

  // plain writeback from the owner
  task automatic t_writeback();
    send_req(2, 3, 1, 119, "R8");
    expect_msg(5, 3, 1, -1, "R8");
    send_req(1, 0, 1, 0, "R8");
    expect_msg(1, 0, 1, 119, "R8");
  endtask

  // writeback crossing a forwarded read
  task automatic t_race();
    three_hop = 1'b1;
    send_req(0, 2, 1, 0, "R9");
    expect_msg(3, 0, 1, -1, "R9");
    send_req(2, 0, 1, 153, "R9");
    expect_quiet(3, "R9");
    send_rsp(2, 0, 1, 1'b0, 153);
    expect_quiet(2, "R9");
    send_req(1, 3, 1, 0, "R9");
    expect_msg(4, 2, 1, -1, "R9");
    send_rsp(0, 2, 1, 1'b0, 0);
    expect_msg(1, 3, 1, 153, "R9");
  endtask

  // writeback from a core that does not own the line
  task automatic t_stray_writeback();
    send_req(2, 1, 2, 238, "R11");
    expect_quiet(4, "R11");
    send_req(0, 1, 2, 0, "R11");
    expect_msg(0, 1, 2, boot_val(2), "R11");
    send_req(1, 2, 2, 0, "R11");
    expect_msg(4, 1, 2, -1, "R11");
    send_rsp(0, 1, 2, 1'b0, 0);
    expect_msg(1, 2, 2, boot_val(2), "R11");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_and_read();
    t_exclusive_with_acks();
    t_recall_path();
    t_forward_path();
    t_writeback();
    t_race();
    t_stray_writeback();
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule